// File: doc/BRIEF.md
# Byte-Operand One-Source Arithmetic Unit

This unit executes the single-operand arithmetic group of a 16-bit-era integer core for byte operands. The three-bit operation code taken from bits 5:3 of the addressing byte selects one of TEST with an immediate, bitwise complement, two's-complement negation, unsigned multiply, signed multiply, unsigned divide and signed divide. The accumulator (AX, with AL as its low byte), the byte operand and the immediate arrive in the cycle that `start` is high. The unit captures them and reports results after a fixed, operation-specific latency. It also reports whether the result goes to the accumulator (`ax_we`) or back to the operand location (`rm_we`), and which flags are written.

Multiplies are formed in one cycle and then padded to their latency. Divides run a restoring shift-subtract loop on the operand magnitudes, one quotient bit per cycle, with a sign fix-up at the end. A quotient that does not fit, or a zero divisor, raises `div_err` in the done cycle with every write enable low. Delivering the error vector is left to the surrounding core. The divide latency must be at least nine cycles so that the eight divide steps finish first.

The control state machine has four states. `S_IDLE` waits for `start`. `S_DIV` runs the divide steps. `S_PAD` holds until the latency budget is spent. `S_DONE` lasts one cycle and presents the results. The transitions are:
- IDLE→DONE on a one-cycle operation.
- IDLE→DIV on a divide.
- IDLE→PAD on any other operation.
- DIV→PAD when the steps finish.
- DIV→DONE or PAD→DONE when the budget counter reaches zero.
- DONE→IDLE always.

Top module: `grp3_alu`

## Requirements
- R1: After reset, `busy`, `done`, `div_err`, `ax_we`, `rm_we` and `flg_we` are all low.
- R2: If `start` is sampled at an edge while idle, `done` is high for exactly one cycle, L cycles later. With default parameters L is:
  - TEST: 1 in register form, 2 in memory form (`mem_form`=1).
  - NOT and NEG: 1 in register form, 3 in memory form.
  - MUL: 13. IMUL: 14. DIV: 16. IDIV: 19.
  `busy` is high from the cycle after the start edge through the done cycle, and falls in the cycle after done. Outside the done cycle all write enables and `div_err` are low.
- R3: `start` has no effect while `busy` is high. The running operation completes with its own operands and latency, and no extra completion follows.
- R4: Codes 0 and 1 are TEST. Let T = operand AND immediate. ZF = (T==0), SF = T[7], PF = 1 when T has an even number of ones, and CF = OF = 0. The flag enable mask is 6'b111011, which leaves AF unwritten. There is no data write. In the flag vectors, bit 0 is CF, 1 is PF, 2 is AF, 3 is ZF, 4 is SF and 5 is OF.
- R5: Code 2 (NOT) writes the complement of the operand with `rm_we`. No flag is written.
- R6: Code 3 (NEG) writes R = 0 − operand with `rm_we` and writes all six flags:
  - CF = (operand≠0); AF = (operand[3:0]≠0); OF = (operand==0x80).
  - ZF, SF and PF are taken from R.
- R7: Code 4 (MUL) writes AX = AL × operand, unsigned. CF and OF are written (mask 6'b100001), and both equal (AX[15:8]≠0).
- R8: Code 5 (IMUL) writes AX as the signed 16-bit product. CF and OF are written, and both are 1 exactly when the product lies outside −128..127.
- R9: Code 6 (DIV) divides AX by the operand, unsigned. AL receives the quotient and AH the remainder. All six flags are written with the fixed pattern `DIV_FLAGS` (default 6'b000010: PF set, the rest clear).
- R10: Code 7 (IDIV) divides AX by the operand as signed values, with the quotient truncated toward zero. The remainder carries the dividend's sign. A quotient of −128 is accepted. The flags are as in R9.
- R11: A divide with a zero divisor, or with a quotient above 255 (DIV) or outside −128..127 (IDIV), raises `div_err` in the done cycle. `ax_we`, `rm_we` and `flg_we` stay low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, taken only while idle |
| op_sel | input | 3 | Operation code (addressing byte bits 5:3) |
| mem_form | input | 1 | Operand comes from memory (longer latency for TEST/NOT/NEG) |
| acc_in | input | 16 | Accumulator AX |
| src_in | input | 8 | Byte operand |
| imm_in | input | 8 | Immediate for TEST |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion strobe |
| div_err | output | 1 | Divide error, valid with done |
| ax_we | output | 1 | Write `res_ax` into AX |
| res_ax | output | 16 | Accumulator result |
| rm_we | output | 1 | Write `res_rm` to the operand location |
| res_rm | output | 8 | Operand-location result |
| flg_we | output | 6 | Per-flag write enables |
| flg_val | output | 6 | Flag values |

## Verification
A wrong state register or budget counter shows up at the ports as `done` arriving a cycle early or late, or as a second pulse. The bench detects this by measuring every latency. A corrupted divide step, remainder or sign choice appears only in the single done cycle, as a wrong AL/AH pair or a wrong `div_err` decision. The divide cases are therefore chosen to sit at the boundaries: quotient 255 against 256, and −128 against +128. A capture register that reloads while busy changes the result of the running operation within its own latency window.

// File: rtl/grp3_pkg.sv
package grp3_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int FLAG_W = 6;
    localparam int LAT_W  = 6;

    localparam int FB_CF = 0;
    localparam int FB_PF = 1;
    localparam int FB_AF = 2;
    localparam int FB_ZF = 3;
    localparam int FB_SF = 4;
    localparam int FB_OF = 5;

    typedef enum logic [2:0] {
        OP_TEST0 = 3'd0,
        OP_TEST1 = 3'd1,
        OP_NOT   = 3'd2,
        OP_NEG   = 3'd3,
        OP_MUL   = 3'd4,
        OP_IMUL  = 3'd5,
        OP_DIV   = 3'd6,
        OP_IDIV  = 3'd7
    } g3_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DIV  = 2'd1,
        S_PAD  = 2'd2,
        S_DONE = 2'd3
    } g3_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] ax;
        logic              ax_we;
        logic [BYTE_W-1:0] rm;
        logic              rm_we;
        logic [FLAG_W-1:0] fwe;
        logic [FLAG_W-1:0] fval;
    } g3_res_t;

    function automatic logic even_parity(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction
endpackage

// File: rtl/grp3_latency.sv
module grp3_latency import grp3_pkg::*; #(
    parameter bit NEWER_CORE  = 1'b1,
    parameter int LAT_RMW_REG = 1,
    parameter int LAT_RMW_MEM = 3,
    parameter int LAT_MUL     = 13,
    parameter int LAT_IMUL    = 14,
    parameter int LAT_IDIV    = 19
) (
    input  g3_op_e           op,
    input  logic             mem_form,
    output logic [LAT_W-1:0] lat
);
    logic [LAT_W-1:0] test_reg, test_mem, div_lat;

    generate
        if (NEWER_CORE) begin : g_newer
            assign test_reg = LAT_W'(1);
            assign test_mem = LAT_W'(2);
            assign div_lat  = LAT_W'(16);
        end else begin : g_older
            assign test_reg = LAT_W'(2);
            assign test_mem = LAT_W'(5);
            assign div_lat  = LAT_W'(14);
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_TEST0, OP_TEST1: lat = mem_form ? test_mem : test_reg;
            OP_NOT, OP_NEG:     lat = mem_form ? LAT_W'(LAT_RMW_MEM) : LAT_W'(LAT_RMW_REG);
            OP_MUL:             lat = LAT_W'(LAT_MUL);
            OP_IMUL:            lat = LAT_W'(LAT_IMUL);
            OP_DIV:             lat = div_lat;
            OP_IDIV:            lat = LAT_W'(LAT_IDIV);
        endcase
    end
endmodule

// File: rtl/grp3_quick.sv
module grp3_quick import grp3_pkg::*; (
    input  g3_op_e            op,
    input  logic [BYTE_W-1:0] al,
    input  logic [BYTE_W-1:0] src,
    input  logic [BYTE_W-1:0] imm,
    output g3_res_t           res
);
    logic [BYTE_W-1:0] and_v, neg_v;
    logic [WORD_W-1:0] uprod, sprod;
    logic              s_ovf;

    assign and_v = src & imm;
    assign neg_v = BYTE_W'(0) - src;
    assign uprod = {{BYTE_W{1'b0}}, al} * {{BYTE_W{1'b0}}, src};
    assign sprod = WORD_W'($signed({{BYTE_W{al[BYTE_W-1]}}, al}) *
                           $signed({{BYTE_W{src[BYTE_W-1]}}, src}));
    assign s_ovf = !((&sprod[WORD_W-1:BYTE_W-1]) || !(|sprod[WORD_W-1:BYTE_W-1]));

    always_comb begin
        res = '0;
        unique case (op)
            OP_TEST0, OP_TEST1: begin
                res.fwe         = FLAG_W'((1 << FB_CF) | (1 << FB_PF) | (1 << FB_ZF) |
                                          (1 << FB_SF) | (1 << FB_OF));
                res.fval[FB_ZF] = (and_v == '0);
                res.fval[FB_SF] = and_v[BYTE_W-1];
                res.fval[FB_PF] = even_parity(and_v);
            end
            OP_NOT: begin
                res.rm_we = 1'b1;
                res.rm    = ~src;
            end
            OP_NEG: begin
                res.rm_we       = 1'b1;
                res.rm          = neg_v;
                res.fwe         = '1;
                res.fval[FB_CF] = (src != '0);
                res.fval[FB_AF] = (src[3:0] != 4'd0);
                res.fval[FB_OF] = (src == {1'b1, {(BYTE_W-1){1'b0}}});
                res.fval[FB_ZF] = (neg_v == '0);
                res.fval[FB_SF] = neg_v[BYTE_W-1];
                res.fval[FB_PF] = even_parity(neg_v);
            end
            OP_MUL: begin
                res.ax_we       = 1'b1;
                res.ax          = uprod;
                res.fwe         = FLAG_W'((1 << FB_CF) | (1 << FB_OF));
                res.fval[FB_CF] = |uprod[WORD_W-1:BYTE_W];
                res.fval[FB_OF] = |uprod[WORD_W-1:BYTE_W];
            end
            OP_IMUL: begin
                res.ax_we       = 1'b1;
                res.ax          = sprod;
                res.fwe         = FLAG_W'((1 << FB_CF) | (1 << FB_OF));
                res.fval[FB_CF] = s_ovf;
                res.fval[FB_OF] = s_ovf;
            end
            OP_DIV, OP_IDIV: res = '0;
        endcase
    end
endmodule

// File: rtl/grp3_divcore.sv
module grp3_divcore #(
    parameter int Q_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2*Q_W-1:0] num,
    input  logic [Q_W-1:0]   den,
    output logic [Q_W-1:0]   quo,
    output logic [Q_W-1:0]   rem,
    output logic             fin
);
    localparam int STEP_W = $clog2(Q_W + 1);

    logic [Q_W-1:0]    rem_q, quo_q;
    logic [STEP_W-1:0] step_q;
    logic [Q_W:0]      trial;
    logic              fits;

    assign trial = {rem_q, quo_q[Q_W-1]};
    assign fits  = (trial >= {1'b0, den});
    assign fin   = (step_q == STEP_W'(Q_W));
    assign quo   = quo_q;
    assign rem   = rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            step_q <= STEP_W'(Q_W);
        end else if (load) begin
            rem_q  <= num[2*Q_W-1:Q_W];
            quo_q  <= num[Q_W-1:0];
            step_q <= '0;
        end else if (!fin) begin
            rem_q  <= fits ? Q_W'(trial - {1'b0, den}) : trial[Q_W-1:0];
            quo_q  <= {quo_q[Q_W-2:0], fits};
            step_q <= step_q + STEP_W'(1);
        end
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !fin && (rem_q < den)) |=> (rem_q < den)); // R9
endmodule

// File: rtl/grp3_alu.sv
module grp3_alu import grp3_pkg::*; #(
    parameter bit                NEWER_CORE  = 1'b1,
    parameter int                LAT_RMW_REG = 1,
    parameter int                LAT_RMW_MEM = 3,
    parameter int                LAT_MUL     = 13,
    parameter int                LAT_IMUL    = 14,
    parameter int                LAT_IDIV    = 19,
    parameter logic [FLAG_W-1:0] DIV_FLAGS   = 6'b000010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic              mem_form,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [BYTE_W-1:0] src_in,
    input  logic [BYTE_W-1:0] imm_in,
    output logic              busy,
    output logic              done,
    output logic              div_err,
    output logic              ax_we,
    output logic [WORD_W-1:0] res_ax,
    output logic              rm_we,
    output logic [BYTE_W-1:0] res_rm,
    output logic [FLAG_W-1:0] flg_we,
    output logic [FLAG_W-1:0] flg_val
);
    g3_state_e         state_q, state_d;
    g3_op_e            op_in, op_q;
    g3_res_t           quick_res, res_q;
    logic [LAT_W-1:0]  lat_in, cnt_q;
    logic              accept, div_in, signed_in;
    logic [WORD_W-1:0] num_mag;
    logic [BYTE_W-1:0] den_mag, den_q;
    logic              qneg_q, rneg_q, sdiv_q, povf_q;
    logic [BYTE_W-1:0] div_quo, div_rem, q_fix, r_fix;
    logic              div_fin, q_fits, derr;

    assign op_in     = g3_op_e'(op_sel);
    assign accept    = start && (state_q == S_IDLE);
    assign div_in    = (op_in == OP_DIV) || (op_in == OP_IDIV);
    assign signed_in = (op_in == OP_IDIV);
    assign num_mag   = (signed_in && acc_in[WORD_W-1]) ? (WORD_W'(0) - acc_in) : acc_in;
    assign den_mag   = (signed_in && src_in[BYTE_W-1]) ? (BYTE_W'(0) - src_in) : src_in;

    grp3_latency #(
        .NEWER_CORE (NEWER_CORE),
        .LAT_RMW_REG(LAT_RMW_REG),
        .LAT_RMW_MEM(LAT_RMW_MEM),
        .LAT_MUL    (LAT_MUL),
        .LAT_IMUL   (LAT_IMUL),
        .LAT_IDIV   (LAT_IDIV)
    ) u_lat (
        .op      (op_in),
        .mem_form(mem_form),
        .lat     (lat_in)
    );

    grp3_quick u_quick (
        .op (op_in),
        .al (acc_in[BYTE_W-1:0]),
        .src(src_in),
        .imm(imm_in),
        .res(quick_res)
    );

    grp3_divcore #(.Q_W(BYTE_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept && div_in),
        .num  (num_mag),
        .den  (den_q),
        .quo  (div_quo),
        .rem  (div_rem),
        .fin  (div_fin)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                if (lat_in == LAT_W'(1)) state_d = S_DONE;
                else if (div_in)         state_d = S_DIV;
                else                     state_d = S_PAD;
            end
            S_DIV: begin
                if (cnt_q == '0)  state_d = S_DONE;
                else if (div_fin) state_d = S_PAD;
            end
            S_PAD:  if (cnt_q == '0) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // state register, latency budget and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_TEST0;
            res_q   <= '0;
            den_q   <= '0;
            qneg_q  <= 1'b0;
            rneg_q  <= 1'b0;
            sdiv_q  <= 1'b0;
            povf_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= (lat_in > LAT_W'(1)) ? (lat_in - LAT_W'(2)) : '0;
                op_q  <= op_in;
                res_q <= quick_res;
                if (div_in) begin
                    den_q  <= den_mag;
                    sdiv_q <= signed_in;
                    qneg_q <= signed_in && (acc_in[WORD_W-1] ^ src_in[BYTE_W-1]);
                    rneg_q <= signed_in && acc_in[WORD_W-1];
                    povf_q <= (num_mag[WORD_W-1:BYTE_W] >= den_mag);
                end
            end else if (((state_q == S_DIV) || (state_q == S_PAD)) && (cnt_q != '0)) begin
                cnt_q <= cnt_q - LAT_W'(1);
            end
        end
    end

    // divide sign fix-up and range decision
    assign q_fix  = qneg_q ? (BYTE_W'(0) - div_quo) : div_quo;
    assign r_fix  = rneg_q ? (BYTE_W'(0) - div_rem) : div_rem;
    assign q_fits = !sdiv_q ||
                    (qneg_q ? (div_quo <= {1'b1, {(BYTE_W-1){1'b0}}})
                            : (div_quo <= {1'b0, {(BYTE_W-1){1'b1}}}));
    assign derr   = povf_q || !q_fits;

    // outputs
    always_comb begin
        busy    = (state_q != S_IDLE);
        done    = (state_q == S_DONE);
        div_err = 1'b0;
        ax_we   = 1'b0;
        res_ax  = '0;
        rm_we   = 1'b0;
        res_rm  = '0;
        flg_we  = '0;
        flg_val = '0;
        if (state_q == S_DONE) begin
            if ((op_q == OP_DIV) || (op_q == OP_IDIV)) begin
                div_err = derr;
                if (!derr) begin
                    ax_we   = 1'b1;
                    res_ax  = {r_fix, q_fix};
                    flg_we  = '1;
                    flg_val = DIV_FLAGS;
                end
            end else begin
                ax_we   = res_q.ax_we;
                res_ax  = res_q.ax;
                rm_we   = res_q.rm_we;
                res_rm  = res_q.rm;
                flg_we  = res_q.fwe;
                flg_val = res_q.fval;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_QUIET_UNLESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!ax_we && !rm_we && !div_err && (flg_we == '0))); // R2
    AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_q)); // R3
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (done && !ax_we && !rm_we && (flg_we == '0))); // R11
    AST_MUL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_MUL)) |-> (flg_val[FB_CF] == (res_ax[WORD_W-1:BYTE_W] != '0))); // R7
    AST_IMUL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_IMUL)) |->
        (flg_val[FB_CF] == !((&res_ax[WORD_W-1:BYTE_W-1]) || !(|res_ax[WORD_W-1:BYTE_W-1])))); // R8
endmodule

// File: tb/tb_grp3_alu.sv
module tb_grp3_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        mem_form = 1'b0;
    logic [15:0] acc_in = 16'h0;
    logic [7:0]  src_in = 8'h0;
    logic [7:0]  imm_in = 8'h0;
    logic        busy, done, div_err, ax_we, rm_we;
    logic [15:0] res_ax;
    logic [7:0]  res_rm;
    logic [5:0]  flg_we, flg_val;

    int n_chk = 0;
    int n_fail = 0;

    // captured results
    int          r_lat;
    logic        r_busy_ok, r_err, r_axwe, r_rmwe;
    logic [15:0] r_ax;
    logic [7:0]  r_rm;
    logic [5:0]  r_fwe, r_fval;
    // expected results
    int          e_lat;
    logic        e_err, e_axwe, e_rmwe;
    logic [15:0] e_ax;
    logic [7:0]  e_rm;
    logic [5:0]  e_fwe, e_fval;

    always #10 clk = ~clk;

    grp3_alu dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .mem_form(mem_form),
        .acc_in(acc_in), .src_in(src_in), .imm_in(imm_in),
        .busy(busy), .done(done), .div_err(div_err),
        .ax_we(ax_we), .res_ax(res_ax), .rm_we(rm_we), .res_rm(res_rm),
        .flg_we(flg_we), .flg_val(flg_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic mem, input logic [15:0] ax,
                          input logic [7:0] s, input logic [7:0] im);
        int k;
        @(negedge clk);
        op_sel = op; mem_form = mem; acc_in = ax; src_in = s; imm_in = im; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        r_busy_ok = 1'b1;
        while (!done && k < 200) begin
            if (!busy) r_busy_ok = 1'b0;
            @(negedge clk);
            k++;
        end
        if (!busy) r_busy_ok = 1'b0;
        r_lat = k; r_err = div_err; r_axwe = ax_we; r_rmwe = rm_we;
        r_ax = res_ax; r_rm = res_rm; r_fwe = flg_we; r_fval = flg_val;
    endtask

    task automatic model(input logic [2:0] op, input logic mem, input logic [15:0] ax,
                         input logic [7:0] s, input logic [7:0] im);
        logic [7:0] t;
        int a, d, q, r, p;
        e_err = 0; e_axwe = 0; e_rmwe = 0; e_ax = 0; e_rm = 0; e_fwe = 0; e_fval = 0;
        case (op)
            3'd0, 3'd1: begin
                e_lat = mem ? 2 : 1;
                t = s & im;
                e_fwe = 6'b111011;
                e_fval = {1'b0, t[7], t == 8'h0, 1'b0, ~^t, 1'b0};
            end
            3'd2: begin
                e_lat = mem ? 3 : 1;
                e_rmwe = 1; e_rm = ~s;
            end
            3'd3: begin
                e_lat = mem ? 3 : 1;
                t = 8'h0 - s;
                e_rmwe = 1; e_rm = t; e_fwe = 6'b111111;
                e_fval = {s == 8'h80, t[7], t == 8'h0, s[3:0] != 4'h0, ~^t, s != 8'h0};
            end
            3'd4: begin
                e_lat = 13;
                p = int'(ax[7:0]) * int'(s);
                e_axwe = 1; e_ax = p[15:0]; e_fwe = 6'b100001;
                e_fval = (p > 255) ? 6'b100001 : 6'b000000;
            end
            3'd5: begin
                e_lat = 14;
                p = int'($signed(ax[7:0])) * int'($signed(s));
                e_axwe = 1; e_ax = p[15:0]; e_fwe = 6'b100001;
                e_fval = (p > 127 || p < -128) ? 6'b100001 : 6'b000000;
            end
            3'd6: begin
                e_lat = 16;
                if (s == 0 || (int'(ax) / int'(s)) > 255) e_err = 1;
                else begin
                    q = int'(ax) / int'(s); r = int'(ax) % int'(s);
                    e_axwe = 1; e_ax = {r[7:0], q[7:0]}; e_fwe = 6'b111111; e_fval = 6'b000010;
                end
            end
            default: begin
                e_lat = 19;
                a = int'($signed(ax)); d = int'($signed(s));
                if (d == 0) e_err = 1;
                else begin
                    q = a / d; r = a % d;
                    if (q > 127 || q < -128) e_err = 1;
                    else begin
                        e_axwe = 1; e_ax = {r[7:0], q[7:0]}; e_fwe = 6'b111111; e_fval = 6'b000010;
                    end
                end
            end
        endcase
    endtask

    task automatic do_case(input string tag, input logic [2:0] op, input logic mem,
                           input logic [15:0] ax, input logic [7:0] s, input logic [7:0] im);
        run_op(op, mem, ax, s, im);
        model(op, mem, ax, s, im);
        chk({tag, " R2 latency"}, r_lat, e_lat);
        chk({tag, " R2 busy held"}, r_busy_ok, 1'b1);
        chk({tag, " err"}, r_err, e_err);
        chk({tag, " ax_we"}, r_axwe, e_axwe);
        if (e_axwe) chk({tag, " ax"}, r_ax, e_ax);
        chk({tag, " rm_we"}, r_rmwe, e_rmwe);
        if (e_rmwe) chk({tag, " rm"}, r_rm, e_rm);
        chk({tag, " flag mask"}, r_fwe, e_fwe);
        chk({tag, " flag values"}, r_fval & r_fwe, e_fval);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 writes", {div_err, ax_we, rm_we, flg_we}, 9'h0);
    endtask

    task automatic t_test();
        do_case("R4 test code0 reg", 3'd0, 1'b0, 16'h0, 8'hF3, 8'h35);
        do_case("R4 test code1 mem", 3'd1, 1'b1, 16'h0, 8'hA5, 8'h5A);
        do_case("R4 test sign", 3'd0, 1'b1, 16'h0, 8'h80, 8'hC0);
    endtask

    task automatic t_not();
        do_case("R5 not reg", 3'd2, 1'b0, 16'h0, 8'h3C, 8'h0);
        do_case("R5 not mem", 3'd2, 1'b1, 16'h0, 8'hFF, 8'h0);
    endtask

    task automatic t_neg();
        do_case("R6 neg zero", 3'd3, 1'b0, 16'h0, 8'h00, 8'h0);
        do_case("R6 neg min", 3'd3, 1'b1, 16'h0, 8'h80, 8'h0);
        do_case("R6 neg one", 3'd3, 1'b0, 16'h0, 8'h01, 8'h0);
        do_case("R6 neg nibble", 3'd3, 1'b0, 16'h0, 8'h30, 8'h0);
    endtask

    task automatic t_mul();
        do_case("R7 mul small", 3'd4, 1'b0, 16'hAA10, 8'h0F, 8'h0);
        do_case("R7 mul max", 3'd4, 1'b0, 16'h00FF, 8'hFF, 8'h0);
    endtask

    task automatic t_imul();
        do_case("R8 imul neg*neg", 3'd5, 1'b0, 16'h00FF, 8'hFF, 8'h0);
        do_case("R8 imul overflow", 3'd5, 1'b0, 16'h0040, 8'h02, 8'h0);
        do_case("R8 imul min", 3'd5, 1'b0, 16'h0080, 8'h01, 8'h0);
    endtask

    task automatic t_div();
        do_case("R9 div basic", 3'd6, 1'b0, 16'h0107, 8'h10, 8'h0);
        do_case("R9 div q255", 3'd6, 1'b0, 16'hFEFF, 8'hFF, 8'h0);
    endtask

    task automatic t_idiv();
        do_case("R10 idiv neg dividend", 3'd7, 1'b0, 16'hFFF9, 8'h02, 8'h0);
        do_case("R10 idiv neg divisor", 3'd7, 1'b0, 16'h0007, 8'hFE, 8'h0);
        do_case("R10 idiv q -128", 3'd7, 1'b0, 16'h4000, 8'h80, 8'h0);
    endtask

    task automatic t_div_err();
        do_case("R11 div by zero", 3'd6, 1'b0, 16'h1234, 8'h00, 8'h0);
        do_case("R11 div q256", 3'd6, 1'b0, 16'h0100, 8'h01, 8'h0);
        do_case("R11 idiv +128", 3'd7, 1'b0, 16'hFF80, 8'hFF, 8'h0);
        do_case("R11 idiv zero", 3'd7, 1'b0, 16'h8000, 8'h00, 8'h0);
    endtask

    task automatic t_ignore();
        int k;
        int extra;
        @(negedge clk);
        op_sel = 3'd4; mem_form = 1'b0; acc_in = 16'h0012; src_in = 8'h03; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 200) begin
            if (k == 3) begin
                op_sel = 3'd6; acc_in = 16'h0; src_in = 8'h0; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        chk("R3 latency unchanged", k, 13);
        chk("R3 result of running op", {div_err, ax_we, res_ax}, {1'b0, 1'b1, 16'h0036});
        @(negedge clk);
        chk("R2 busy falls after done", {busy, done}, 2'b00);
        extra = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        chk("R3 no launch from ignored start", extra, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_test();
        t_not();
        t_neg();
        t_mul();
        t_imul();
        t_div();
        t_idiv();
        t_div_err();
        t_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule